// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a countdown watchdog controlled through a small 32-bit register port. Software programs a reload value and a reset-pulse width. Starting or halting the countdown takes a two-word key written to the key register; no single control bit does it. A halt sequence also restores the reload value into the live counter. While armed, the counter steps down once for each reference tick, which is a one-cycle strobe from the 40 MHz reference clock. When the count runs out, the block drives a reset output for a programmed number of reference ticks and latches an interrupt flag.

The register port is a plain write strobe with a word address. Read data is combinational from the address. There is no data stream and no back-pressure: every write takes effect in the cycle it is presented. The registers are:
- word 0: reload value. Writes set the reload value; reads return the live count.
- word 1: keys. Reads return bit 0 = running.
- word 2: pulse width.
- word 3: status, with the expiry flag at bit 3.

Top module: `keyed_watchdog`

## Requirements
- R1: Writing 0x0000FF00 to word 1 and then 0x000000FF to word 1 as the next write, while stopped, loads the live count from the reload value and sets running (word 1 bit 0).
- R2: Writing 0x0000EE00 to word 1 and then 0x000000EE to word 1 as the next write clears running and copies the reload value into the live count.
- R3: A key pair completes only if its second word is the very next register write. Idle cycles between the two words are allowed. Any other write in between, to any word or with any other value, cancels the pending first word.
- R4: A completed start pair while already running leaves the live count unchanged.
- R5: While running, the live count drops by exactly one on each reference tick and holds in cycles without a tick.
- R6: When a tick arrives with the live count at 1 or 0, the count becomes 0, running clears and an expiry event occurs. The counter then waits for a new start pair.
- R7: On expiry `wd_reset` rises in the next cycle. It stays high for W+1 reference ticks, where W is word 2, so W = 0 gives a one-tick pulse.
- R8: Expiry sets status bit 3 (read value 0x08) and drives `wd_irq`. Writing word 3 with bit 3 set clears it, and a write with bit 3 clear leaves it.
- R9: A read of word 0 returns the live count, not the reload value. Word 2 reads back its programmed width.
- R10: After reset all four words read 0 and `wd_reset` and `wd_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| ref_tick | input | 1 | one-cycle strobe per reference clock period |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 2 | register word address |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for `reg_addr` |
| wd_reset | output | 1 | watchdog reset pulse |
| wd_irq | output | 1 | expiry interrupt flag |

## Verification
The assertions assume that `ref_tick` is a clean synchronous strobe and that the count fits in the counter width. They also assume that a halt pair may coincide with a tick, in which case the halt wins. The stimulus applies each tick for a single cycle, followed by an idle cycle. Register writes are one cycle long and never overlap a tick that is meant to expire the counter, so each expected value is tied to one event.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] KEY_RUN_A  = 32'h0000_FF00;
  localparam logic [DATA_W-1:0] KEY_RUN_B  = 32'h0000_00FF;
  localparam logic [DATA_W-1:0] KEY_HALT_A = 32'h0000_EE00;
  localparam logic [DATA_W-1:0] KEY_HALT_B = 32'h0000_00EE;
  localparam int STAT_BIT = 3;

  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_KEY   = 2'd1,
    REG_WIDTH = 2'd2,
    REG_STAT  = 2'd3
  } wdt_reg_e;

  typedef enum logic [1:0] {
    ARM_NONE = 2'd0,
    ARM_RUN  = 2'd1,
    ARM_HALT = 2'd2
  } arm_e;
endpackage

// File: rtl/wdt_key_match.sv
module wdt_key_match
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              key_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              start_o,
  output logic              stop_o
);
  arm_e arm_q;
  logic key_wr;

  assign key_wr  = wr_i && key_sel_i;
  assign start_o = key_wr && (arm_q == ARM_RUN)  && (wdata_i == KEY_RUN_B);
  assign stop_o  = key_wr && (arm_q == ARM_HALT) && (wdata_i == KEY_HALT_B);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q <= ARM_NONE;
    end else if (wr_i) begin
      if (key_wr && wdata_i == KEY_RUN_A)       arm_q <= ARM_RUN;
      else if (key_wr && wdata_i == KEY_HALT_A) arm_q <= ARM_HALT;
      else                                      arm_q <= ARM_NONE;
    end
  end

  // R3: a completed pair always consumes the pending first word
  p_pair_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o || stop_o) |=> !(start_o || stop_o));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] dflt_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             run_q;
  logic             last_step;

  assign last_step = count_q <= ONE;
  assign fire_o    = run_q && tick_i && !stop_i && last_step;
  assign count_o   = count_q;
  assign run_o     = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
    end else if (stop_i) begin
      run_q   <= 1'b0;
      count_q <= dflt_i;
    end else if (start_i && !run_q) begin
      run_q   <= 1'b1;
      count_q <= dflt_i;
    end else if (run_q && tick_i) begin
      if (last_step) begin
        count_q <= '0;
        run_q   <= 1'b0;
      end else begin
        count_q <= count_q - ONE;
      end
    end
  end

  p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick_i && !stop_i) |=> (count_q == $past(count_q)));

  p_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && start_i && !tick_i && !stop_i) |=> run_q && (count_q == $past(count_q)));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_i && !stop_i && !last_step) |=> (count_q == $past(count_q) - ONE));

  p_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (!run_q && count_q == '0));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            fire_i,
  input  logic [PW_W-1:0] width_i,
  output logic            rst_o
);
  logic [PW_W-1:0] left_q;
  logic            act_q;

  assign rst_o = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      left_q <= '0;
    end else if (fire_i) begin
      act_q  <= 1'b1;
      left_q <= width_i;
    end else if (act_q && tick_i) begin
      if (left_q == '0) act_q  <= 1'b0;
      else              left_q <= left_q - PW_W'(1);
    end
  end

  p_fire_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> rst_o);

  p_last_tick_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && tick_i && left_q == '0 && !fire_i) |=> !rst_o);

  p_hold_between_ticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !tick_i) |=> rst_o);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PW_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        wd_reset,
  output logic        wd_irq
);
  logic [CNT_W-1:0] dflt_q;
  logic [PW_W-1:0]  width_q;
  logic             flag_q;
  logic [CNT_W-1:0] live_cnt;
  logic             running;
  logic             fire;
  logic             start_k;
  logic             stop_k;
  logic             clr_w1c;
  wdt_reg_e         sel;

  assign sel     = wdt_reg_e'(reg_addr);
  assign clr_w1c = reg_wr && (sel == REG_STAT) && reg_wdata[STAT_BIT];

  wdt_key_match u_keys (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr),
    .key_sel_i (sel == REG_KEY),
    .wdata_i   (reg_wdata),
    .start_o   (start_k),
    .stop_o    (stop_k)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (ref_tick),
    .start_i (start_k),
    .stop_i  (stop_k),
    .dflt_i  (dflt_q),
    .count_o (live_cnt),
    .run_o   (running),
    .fire_o  (fire)
  );

  wdt_pulse #(.PW_W(PW_W)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (ref_tick),
    .fire_i  (fire),
    .width_i (width_q),
    .rst_o   (wd_reset)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dflt_q  <= '0;
      width_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (reg_wr && sel == REG_LOAD)  dflt_q  <= reg_wdata[CNT_W-1:0];
      if (reg_wr && sel == REG_WIDTH) width_q <= reg_wdata[PW_W-1:0];
      if (fire)         flag_q <= 1'b1;
      else if (clr_w1c) flag_q <= 1'b0;
    end
  end

  assign wd_irq = flag_q;

  always_comb begin
    reg_rdata = '0;
    case (sel)
      REG_LOAD:  reg_rdata[CNT_W-1:0] = live_cnt;
      REG_KEY:   reg_rdata[0]         = running;
      REG_WIDTH: reg_rdata[PW_W-1:0]  = width_q;
      REG_STAT:  reg_rdata[STAT_BIT]  = flag_q;
      default:   reg_rdata            = '0;
    endcase
  end

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> wd_irq);

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w1c && !fire) |=> !wd_irq);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_irq && !clr_w1c) |=> wd_irq);
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wd_reset;
  logic        wd_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  longint m_def, m_cnt, m_pw, m_left;
  int m_run, m_pend, m_rst, m_flag;

  always #2.5 clk = ~clk;

  keyed_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wd_reset(wd_reset), .wd_irq(wd_irq)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_def = 0; m_cnt = 0; m_pw = 0; m_left = 0;
      m_run = 0; m_pend = 0; m_rst = 0; m_flag = 0;
    end else begin
      int st, sp, fire;
      st = (reg_wr && reg_addr == 1 && m_pend == 1 && reg_wdata == 32'hFF) ? 1 : 0;
      sp = (reg_wr && reg_addr == 1 && m_pend == 2 && reg_wdata == 32'hEE) ? 1 : 0;
      fire = (m_run && ref_tick && !sp && m_cnt <= 1) ? 1 : 0;
      if (reg_wr) begin
        if (reg_addr == 1 && reg_wdata == 32'hFF00) m_pend = 1;
        else if (reg_addr == 1 && reg_wdata == 32'hEE00) m_pend = 2;
        else m_pend = 0;
      end
      if (fire) begin m_rst = 1; m_left = m_pw; end
      else if (m_rst && ref_tick) begin
        if (m_left == 0) m_rst = 0; else m_left--;
      end
      if (fire) m_flag = 1;
      else if (reg_wr && reg_addr == 3 && reg_wdata[3]) m_flag = 0;
      if (sp) begin m_run = 0; m_cnt = m_def; end
      else if (st && !m_run) begin m_run = 1; m_cnt = m_def; end
      else if (m_run && ref_tick) begin
        if (m_cnt <= 1) begin m_cnt = 0; m_run = 0; end else m_cnt--;
      end
      if (reg_wr && reg_addr == 0) m_def = reg_wdata;
      if (reg_wr && reg_addr == 2) m_pw = reg_wdata[15:0];
    end
  end

  // per-clock comparison against the model (R7, R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R7 wd_reset vs model", wd_reset, m_rst);
      check("R8 wd_irq vs model", wd_irq, m_flag);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic tick1();
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input longint exp, input string req);
    longint mexp;
    @(negedge clk); reg_addr = a; #1;
    check(req, reg_rdata, exp);
    case (a)
      2'd0: mexp = m_cnt;
      2'd1: mexp = m_run;
      2'd2: mexp = m_pw;
      default: mexp = m_flag * 8;
    endcase
    check({req, " model"}, reg_rdata, mexp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd(0, 0, "R10 word0"); rd(1, 0, "R10 word1"); rd(2, 0, "R10 word2"); rd(3, 0, "R10 word3");
    check("R10 wd_reset", wd_reset, 0);
    // R9 live count differs from reload value
    wr(0, 5); wr(2, 2);
    rd(0, 0, "R9 live count not reload"); rd(2, 2, "R9 width readback");
    // R1 start
    wr(1, 32'hFF00); wr(1, 32'hFF);
    rd(1, 1, "R1 running"); rd(0, 5, "R1 count loaded");
    // R5 decrement and hold
    tick1(); tick1();
    rd(0, 3, "R5 two ticks");
    repeat (3) @(negedge clk);
    rd(0, 3, "R5 hold without tick");
    // R4 restart ignored
    wr(1, 32'hFF00); wr(1, 32'hFF);
    rd(0, 3, "R4 count unchanged"); rd(1, 1, "R4 still running");
    // R2 stop reloads
    wr(1, 32'hEE00); wr(1, 32'hEE);
    rd(0, 5, "R2 reload"); rd(1, 0, "R2 stopped");
    tick1();
    rd(0, 5, "R2 no count when stopped");
    // R3 broken sequences
    wr(1, 32'hFF00); wr(2, 2); wr(1, 32'hFF);
    rd(1, 0, "R3 intervening write");
    wr(1, 32'hFF00); wr(1, 32'hEE);
    rd(1, 0, "R3 mismatched second word");
    wr(1, 32'hEE00); wr(1, 32'hFF);
    rd(1, 0, "R3 mismatched halt/run");
    wr(1, 32'hFF00); repeat (3) @(negedge clk); wr(1, 32'hFF);
    rd(1, 1, "R3 idle gap allowed"); rd(0, 5, "R3 count loaded");
    // R6 expiry
    repeat (4) tick1();
    rd(0, 1, "R6 one left"); check("R6 no reset yet", wd_reset, 0);
    tick1();
    rd(0, 0, "R6 count zero"); rd(1, 0, "R6 stopped");
    check("R7 reset high", wd_reset, 1); check("R8 irq", wd_irq, 1);
    rd(3, 8, "R8 status bit3");
    // R7 width 2 -> three ticks
    tick1(); tick1();
    check("R7 still high after 2 ticks", wd_reset, 1);
    tick1();
    check("R7 low after 3 ticks", wd_reset, 0);
    rd(0, 0, "R6 waits for start");
    // R8 write one to clear
    wr(3, 0);
    check("R8 zero write keeps flag", wd_irq, 1);
    wr(3, 8);
    check("R8 cleared", wd_irq, 0); rd(3, 0, "R8 status cleared");
    // R7 zero width
    wr(2, 0); wr(0, 1); wr(1, 32'hFF00); wr(1, 32'hFF);
    tick1();
    check("R7 zero width high", wd_reset, 1);
    tick1();
    check("R7 zero width one tick", wd_reset, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule